// File: doc/BRIEF.md
# Reversible Circuit Depth Layering Unit

This block measures the depth of a reversible gate list while the list streams past. Each gate arrives as a descriptor: a mask of control lines and the index of the target line, over a fixed number of circuit lines. The gate order is never changed. The block groups consecutive gates into layers, where no two gates in a layer use a common line. It tags every gate with the number of the layer it lands in. When the host signals the end of a circuit, the block captures the total depth and the number of gates.

Grouping is greedy. The block keeps a register of the lines used in the open layer. A gate that avoids every one of those lines joins the open layer. A gate that hits any of them closes that layer and opens the next one, and its own lines become the new contents of the register. Because layers are contiguous runs of the input order, two circuits that compute the same function but list their gates differently can report different depths.

Gates enter on a valid/ready channel and leave at once, in the same cycle, on a valid/ready tag channel. A gate transfers only when `gate_valid` and `gate_ready` are both high. `gate_ready` copies `tag_ready`, so any stall downstream reaches the source in the same cycle. A source that is stalled must hold the descriptor steady. `gate_ready` is also low while either control strobe is high. The control strobes and the result pins are plain signals with no handshake.

Top module: `rev_depth_layer`

## Requirements
- R1: A gate's line set is its control mask OR'ed with a one-hot bit at its target index (bit i is line i). The gate joins the open layer exactly when its line set shares no bit with the union of the line sets already in that layer.
- R2: A gate whose line set overlaps the open layer gets the previous layer number plus one. After it, the open layer holds only that gate's lines.
- R3: Layers are numbered from 1. The first gate after reset, `clr` or `eoc` is tagged 1.
- R4: `tag_valid` equals `gate_valid`. While a gate is offered, `tag_layer` carries that gate's layer number in the same cycle, with no register between them.
- R5: While `tag_ready` is low, `gate_ready` is low and no state changes. A held gate is tagged exactly as it would have been without the stall.
- R6: A one-cycle `eoc` sets `res_valid` on the next cycle. At the same time `res_depth` takes the number of layers opened and `res_gates` takes the number of gates accepted since the last restart. After that, counting starts again from an empty circuit.
- R7: An `eoc` with no gates accepted since the last restart reports depth 0 and 0 gates.
- R8: A one-cycle `clr` empties the open layer and zeroes depth and gate count. On the next cycle it drops `res_valid` and zeroes `res_depth` and `res_gates`. While `clr` or `eoc` is high, `gate_ready` is low.
- R9: After reset, `res_valid`, `res_depth` and `res_gates` are all 0.
- R10: On 4 lines, take the sequence: control 0 to target 1, control 2 to target 0, NOT on 1, NOT on 3, controls 0 and 3 to target 1, NOT on 2. It is tagged 1,2,2,2,3,3 and reports 6 gates at depth 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Drop the running circuit and the held result |
| eoc | input | 1 | End of circuit: capture depth and gate count, then restart |
| gate_valid | input | 1 | Descriptor offered |
| gate_ready | output | 1 | Descriptor can be taken this cycle |
| gate_ctrl | input | LINES | Control-line mask |
| gate_tgt | input | TGT_W | Target line index |
| tag_valid | output | 1 | Layer tag offered |
| tag_ready | input | 1 | Consumer takes the tag |
| tag_layer | output | CNT_W | Layer number of the offered gate |
| res_valid | output | 1 | Result holds a captured circuit |
| res_depth | output | CNT_W | Captured depth |
| res_gates | output | CNT_W | Captured gate count |

## Verification
The assertions assume the following about the inputs:
- the target index is below the line count;
- the target line is not also set in the control mask;
- `clr` and `eoc` are single-cycle strobes sent while no gate is pending.

Under those assumptions, the layer tags of consecutive gates can only stay the same or rise by one, and a captured depth can never exceed the captured gate count. The stimulus builds every control mask with the target bit cleared and draws targets only from valid indices. It sends the strobes only between gate transfers, and it lowers `tag_ready` at random so that held gates are tagged after a stall.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  // Next-layer decision for one incoming gate.
  typedef struct packed {
    logic open_new;   // gate starts a fresh layer
    logic collide;    // gate touches a line already in the open layer
  } rdl_step_t;
endpackage

// File: rtl/rdl_lineset.sv
module rdl_lineset #(
  parameter int LINES = 8,
  parameter int TGT_W = 3
) (
  input  logic [LINES-1:0] ctrl_mask,
  input  logic [TGT_W-1:0] tgt_idx,
  output logic [LINES-1:0] line_set
);
  // One bit per line: controls plus the decoded target.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line_set[i] = ctrl_mask[i] | (tgt_idx == TGT_W'(i));
  end
endmodule

// File: rtl/rdl_layer_track.sv
module rdl_layer_track
  import rdl_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             take,
  input  logic [LINES-1:0] line_set,
  output logic [CNT_W-1:0] layer_now,
  output logic [CNT_W-1:0] depth
);
  logic [LINES-1:0] occ_q;
  logic [CNT_W-1:0] depth_q;
  rdl_step_t        step;

  always_comb begin
    step.collide  = |(occ_q & line_set);
    step.open_new = (depth_q == '0) | step.collide;
    layer_now     = step.open_new ? depth_q + CNT_W'(1) : depth_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q   <= '0;
      depth_q <= '0;
    end else if (restart) begin
      occ_q   <= '0;
      depth_q <= '0;
    end else if (take) begin
      depth_q <= layer_now;
      occ_q   <= step.open_new ? line_set : (occ_q | line_set);
    end
  end

  assign depth = depth_q;
endmodule

// File: rtl/rdl_tally.sv
module rdl_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             eoc,
  input  logic             take,
  input  logic [CNT_W-1:0] depth,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_depth,
  output logic [CNT_W-1:0] res_gates
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      res_valid <= 1'b0;
      res_depth <= '0;
      res_gates <= '0;
    end else if (clr) begin
      cnt_q     <= '0;
      res_valid <= 1'b0;
      res_depth <= '0;
      res_gates <= '0;
    end else if (eoc) begin
      cnt_q     <= '0;
      res_valid <= 1'b1;
      res_depth <= depth;
      res_gates <= cnt_q;
    end else if (take) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rev_depth_layer.sv
module rev_depth_layer #(
  parameter int LINES = 8,
  parameter int CNT_W = 16,
  localparam int TGT_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             eoc,
  input  logic             gate_valid,
  output logic             gate_ready,
  input  logic [LINES-1:0] gate_ctrl,
  input  logic [TGT_W-1:0] gate_tgt,
  output logic             tag_valid,
  input  logic             tag_ready,
  output logic [CNT_W-1:0] tag_layer,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_depth,
  output logic [CNT_W-1:0] res_gates
);
  logic [LINES-1:0] line_set;
  logic [CNT_W-1:0] depth;
  logic             take;

  assign gate_ready = tag_ready & ~clr & ~eoc;
  assign tag_valid  = gate_valid;
  assign take       = gate_valid & gate_ready;

  rdl_lineset #(.LINES(LINES), .TGT_W(TGT_W)) u_lineset (
    .ctrl_mask(gate_ctrl),
    .tgt_idx  (gate_tgt),
    .line_set (line_set)
  );

  rdl_layer_track #(.LINES(LINES), .CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (clr | eoc),
    .take     (take),
    .line_set (line_set),
    .layer_now(tag_layer),
    .depth    (depth)
  );

  rdl_tally #(.CNT_W(CNT_W)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .eoc      (eoc),
    .take     (take),
    .depth    (depth),
    .res_valid(res_valid),
    .res_depth(res_depth),
    .res_gates(res_gates)
  );
endmodule

// File: rtl/rev_depth_layer_chk.sv
module rev_depth_layer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             eoc,
  input logic             gate_valid,
  input logic             gate_ready,
  input logic             tag_ready,
  input logic [CNT_W-1:0] tag_layer,
  input logic             res_valid,
  input logic [CNT_W-1:0] res_depth,
  input logic [CNT_W-1:0] res_gates
);
  logic             seen;
  logic [CNT_W-1:0] last_layer;
  logic             fire;

  assign fire = gate_valid & gate_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen       <= 1'b0;
      last_layer <= '0;
    end else if (clr | eoc) begin
      seen       <= 1'b0;
    end else if (fire) begin
      seen       <= 1'b1;
      last_layer <= tag_layer;
    end
  end

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_ready |-> !gate_ready);
  assert_strobe_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || eoc) |-> !gate_ready);
  assert_first_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !seen) |-> (tag_layer == CNT_W'(1)));
  assert_layer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen) |-> (tag_layer == last_layer || tag_layer == last_layer + CNT_W'(1)));
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !clr) |=> res_valid);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!res_valid && res_gates == '0));
  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_depth <= res_gates));
  assert_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_gates == '0) |-> (res_depth == '0));
endmodule

bind rev_depth_layer rev_depth_layer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .eoc       (eoc),
  .gate_valid(gate_valid),
  .gate_ready(gate_ready),
  .tag_ready (tag_ready),
  .tag_layer (tag_layer),
  .res_valid (res_valid),
  .res_depth (res_depth),
  .res_gates (res_gates)
);

// File: tb/rev_depth_layer_bench.sv
module rev_depth_layer_bench;
  localparam int LINES = 8;
  localparam int CNT_W = 16;
  localparam int TGT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, eoc = 1'b0;
  logic gate_valid = 1'b0;
  logic gate_ready;
  logic [LINES-1:0] gate_ctrl = '0;
  logic [TGT_W-1:0] gate_tgt = '0;
  logic tag_valid;
  logic tag_ready = 1'b1;
  logic [CNT_W-1:0] tag_layer;
  logic res_valid;
  logic [CNT_W-1:0] res_depth, res_gates;

  int checks = 0, fails = 0;
  int exp_q[$];
  logic [LINES-1:0] m_occ = '0;
  int m_depth = 0, m_cnt = 0;
  bit bp_en = 1'b0;

  always #2.5 clk = ~clk;

  rev_depth_layer #(.LINES(LINES), .CNT_W(CNT_W)) u_rev_depth_layer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .eoc(eoc),
    .gate_valid(gate_valid), .gate_ready(gate_ready),
    .gate_ctrl(gate_ctrl), .gate_tgt(gate_tgt),
    .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_layer(tag_layer),
    .res_valid(res_valid), .res_depth(res_depth), .res_gates(res_gates)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: bench model of greedy layering (R1, R2, R3), expected tag queued.
  task automatic send_gate(input logic [LINES-1:0] c, input int t);
    logic [LINES-1:0] ls;
    ls = c | (LINES'(1) << t);
    if (m_depth == 0 || (m_occ & ls) != '0) begin
      m_depth++;
      m_occ = ls;
    end else begin
      m_occ = m_occ | ls;
    end
    m_cnt++;
    exp_q.push_back(m_depth);
    gate_ctrl  = c;
    gate_tgt   = TGT_W'(t);
    gate_valid = 1'b1;
    @(negedge clk);
    while (!gate_ready) @(negedge clk);
    @(posedge clk);
    #1 gate_valid = 1'b0;
  endtask

  task automatic reset_model();
    m_occ = '0; m_depth = 0; m_cnt = 0;
  endtask

  task automatic end_circuit(input string req);
    eoc = 1'b1;
    @(negedge clk);
    chk(gate_ready == 1'b0, "R8 ready low during eoc", gate_ready, 0);
    @(posedge clk);
    #1 eoc = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b1, {req, " res_valid"}, res_valid, 1);
    chk(res_depth == CNT_W'(m_depth), {req, " depth"}, res_depth, m_depth);
    chk(res_gates == CNT_W'(m_cnt), {req, " gates"}, res_gates, m_cnt);
    reset_model();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    clr = 1'b1;
    @(negedge clk);
    chk(gate_ready == 1'b0, "R8 ready low during clr", gate_ready, 0);
    @(posedge clk);
    #1 clr = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 res_valid cleared", res_valid, 0);
    chk(res_gates == '0, "R8 res_gates cleared", res_gates, 0);
    reset_model();
    @(posedge clk);
    #1;
  endtask

  // Monitor: pops expected tags at every transfer (R4).
  always @(negedge clk) begin
    if (rst_n) begin
      if (!tag_ready) chk(gate_ready == 1'b0, "R5 ready follows stall", gate_ready, 0);
      if (gate_valid && gate_ready) begin
        chk(tag_valid == gate_valid, "R4 tag_valid", tag_valid, gate_valid);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected tag", tag_layer, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(tag_layer == CNT_W'(e), "R1/R2 layer tag", tag_layer, e);
        end
      end
    end
  end

  // Downstream stall pattern (R5).
  always @(posedge clk) begin
    #1 tag_ready = bp_en ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(res_valid == 1'b0, "R9 res_valid", res_valid, 0);
    chk(res_depth == '0, "R9 res_depth", res_depth, 0);
    chk(res_gates == '0, "R9 res_gates", res_gates, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R10 worked sequence on lines 0..3
    send_gate(8'b0000_0001, 1);
    send_gate(8'b0000_0100, 0);
    send_gate(8'b0000_0000, 1);
    send_gate(8'b0000_0000, 3);
    send_gate(8'b0000_1001, 1);
    send_gate(8'b0000_0000, 2);
    chk(m_depth == 3 && m_cnt == 6, "R10 model", m_depth, 3);
    end_circuit("R10");
    chk(res_depth == 3, "R10 depth literal", res_depth, 3);
    chk(res_gates == 6, "R10 gates literal", res_gates, 6);

    // R7 empty circuit
    end_circuit("R7");

    // R1 disjoint gates share one layer
    for (int i = 0; i < LINES; i++) send_gate('0, i);
    end_circuit("R1 disjoint");

    // R2 every gate on line 5 opens a new layer; R3/R6 restart after eoc
    for (int i = 0; i < 5; i++) send_gate(8'b0010_0000, 4);
    end_circuit("R2 chain");

    // R5 random gates under random stalls
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      int t;
      logic [LINES-1:0] c;
      t = $urandom_range(0, LINES - 1);
      c = LINES'($urandom & $urandom) & ~(LINES'(1) << t);
      send_gate(c, t);
    end
    bp_en = 1'b0;
    @(posedge clk); #1;
    end_circuit("R5 stall");

    // R8 clear mid-circuit, then a fresh circuit starting at layer 1
    send_gate(8'b0000_0011, 2);
    send_gate(8'b0000_0100, 3);
    end_circuit("R6 before clear");
    send_gate(8'b0000_0001, 1);
    clear_all();
    chk(res_depth == '0, "R8 res_depth cleared", res_depth, 0);
    send_gate(8'b0000_0010, 6);
    send_gate(8'b0000_0000, 6);
    end_circuit("R8 after clear");

    chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule